// File: doc/BRIEF.md
# Manchester Serial Word Encoder

The block turns a captured parallel word into a biphase (Manchester) serial stream. A frame starts with a sync cell. A flag cell follows, then the payload sent most significant bit first, then an optional parity cell. Each bit cell lasts `CELL_CLKS` clocks, which is four by default, so the bit rate is a quarter of the clock rate. The payload is either the wide data word or a short 4-bit word, chosen by a select input.

Software or a host sequencer holds `load_n` low to present the word. The low level also aborts any frame in flight and clears the running parity. The rising edge of `load_n` captures the data. A later rising edge on the asynchronous `start_async` input launches one frame. The complementary output pair either drives the line or loops back for self-test. The pair that is not in use is parked at a fixed level. `tx_idle` is high whenever no frame is in flight.

Top module: `manch_word_tx`

## Requirements
- R1: After reset, and while `load_n` is low, `tx_idle` is 1 and no frame starts, even if `start_async` rises.
- R2: Every bit cell lasts `CELL_CLKS` clocks. A 1 is sent high for the first half-cell and low for the second half. A 0 is sent low then high.
- R3: While a frame is in flight, the negative output of the active pair is the inverse of its positive output.
- R4: The frame order is: sync cell (value `SYNC_BIT`, default 1), then the flag cell, then the payload MSB first. The data comes from the rising edge of `load_n`, and later changes on the data inputs have no effect on the frame.
- R5: With `sel_len35`=1 the frame has 35 cells, the last being parity. With only `sel_len34`=1 it has 34 cells and no parity. With both low, a start edge is ignored. `tx_idle` falls for exactly the frame's cell count times `CELL_CLKS` clocks.
- R6: The parity cell is chosen so that the number of ones over sync, flag, payload and parity is even when `odd_par`=0 and odd when `odd_par`=1.
- R7: With `sel_short`=1 the payload is the 4-bit short word. The frame is then 6 cells, or 7 cells with parity.
- R8: With `line_mode`=1 the line pair carries the frame and both loopback outputs are 0. With `line_mode`=0 the loopback pair carries the frame and both line outputs are 1. Between frames the carrying pair is 00.
- R9: The first clock edge that samples `start_async` high is followed by two more edges, and `tx_idle` falls after the third. A start edge during a frame is ignored and does not launch a second frame.
- R10: Pulling `load_n` low during a frame ends it at the next clock edge, and the next frame carries correct parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CELL_CLKS` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Low: present data, abort, clear parity; rising edge captures |
| word_in | input | DATA_W | Wide payload word |
| flag_in | input | 1 | Flag cell value sent after sync |
| short_in | input | SHORT_W | Short payload word |
| start_async | input | 1 | Asynchronous start request, rising edge active |
| sel_len34 | input | 1 | Frame without parity |
| sel_len35 | input | 1 | Frame with trailing parity (wins over `sel_len34`) |
| sel_short | input | 1 | Use the short payload |
| odd_par | input | 1 | 0 even parity, 1 odd parity |
| line_mode | input | 1 | 1 line pair carries, 0 loopback pair carries |
| line_p | output | 1 | Line data, true |
| line_n | output | 1 | Line data, complement |
| loop_p | output | 1 | Self-test data, true |
| loop_n | output | 1 | Self-test data, complement |
| tx_idle | output | 1 | High when no frame is in flight |

## Verification
The assertions take `load_n` and `line_mode` to be synchronous to `clk`. They also take the data and select inputs to be stable around the rising edge of `load_n` and the start edge. Only `start_async` is allowed to change freely. The bench drives every input on the falling edge. It changes the data inputs only while `load_n` is low or after capture, and in the second case it deliberately inverts them to show they are ignored. Start pulses are held for several clocks so that the synchronizer always sees them.

// File: rtl/mwt_pkg.sv
// Shared types and helpers for the Manchester word encoder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mwt_pkg;

    // Which part of the frame the current cell belongs to.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_FLAG = 2'd1,
        SEG_BODY = 2'd2,
        SEG_PAR  = 2'd3
    } seg_e;

    // Line level of a biphase cell: a 1 goes high then low, a 0 low then high.
    function automatic logic manch_level(input logic bit_val, input logic first_half);
        return first_half ? bit_val : ~bit_val;
    endfunction

endpackage

// File: rtl/mwt_start_sync.sv
// Brings the asynchronous start request into the clock domain and
// produces a one-clock pulse on its rising edge.
// Assumes the request stays high for at least STAGES+1 clocks.
module mwt_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic start_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Metastability chain plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], req_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign start_pulse = sync_q[STAGES-1] & ~last_q;

    // R9
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

endmodule

// File: rtl/mwt_frame_ctrl.sv
// Frame sequencer: captures the data on the load edge, then for each frame
// steps through sync, flag, payload and optional parity cells, CELL_CLKS
// clocks each. It provides the current bit and which half-cell is active.
// Assumes load_n is synchronous and CELL_CLKS is even and at least 2.
module mwt_frame_ctrl
    import mwt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SHORT_W   = 4,
    parameter int CELL_CLKS = 4,
    parameter bit SYNC_BIT  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [DATA_W-1:0]  word_in,
    input  logic               flag_in,
    input  logic [SHORT_W-1:0] short_in,
    input  logic               start_pulse,
    input  logic               sel_len34,
    input  logic               sel_len35,
    input  logic               sel_short,
    input  logic               odd_par,
    output logic               active,
    output logic               cur_bit,
    output logic               first_half
);
    localparam int CYC_W = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;
    localparam int IDX_W = $clog2(DATA_W + 4);
    localparam logic [CYC_W-1:0] CELL_LAST = CYC_W'(CELL_CLKS - 1);
    localparam logic [CYC_W-1:0] HALF      = CYC_W'(CELL_CLKS / 2);
    localparam logic [IDX_W-1:0] DATA_LAST  = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_W + 1);

    logic               load_q;
    logic [DATA_W-1:0]  word_q, sh_word;
    logic [SHORT_W-1:0] short_q, sh_short;
    logic               flag_q;
    logic [CYC_W-1:0]   cyc;
    logic [IDX_W-1:0]   idx, body_last, last_idx;
    logic               short_lat, odd_lat, par_acc;
    logic               start_ok, cell_end;
    seg_e               seg;

    assign start_ok = start_pulse && load_n && load_q && (sel_len34 || sel_len35);
    assign cell_end = active && (cyc == CELL_LAST);

    // Capture data registers on the rising edge of load_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b1;
            word_q  <= '0;
            short_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            load_q <= load_n;
            if (load_n && !load_q) begin
                word_q  <= word_in;
                short_q <= short_in;
                flag_q  <= flag_in;
            end
        end
    end

    // Frame state: activity, cell timer, cell index and latched options.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cyc       <= '0;
            idx       <= '0;
            body_last <= DATA_LAST;
            last_idx  <= DATA_LAST;
            short_lat <= 1'b0;
            odd_lat   <= 1'b0;
        end else if (!load_n) begin
            active <= 1'b0;
            cyc    <= '0;
            idx    <= '0;
        end else if (!active) begin
            if (start_ok) begin
                active    <= 1'b1;
                cyc       <= '0;
                idx       <= '0;
                short_lat <= sel_short;
                odd_lat   <= odd_par;
                body_last <= sel_short ? SHORT_LAST : DATA_LAST;
                last_idx  <= (sel_short ? SHORT_LAST : DATA_LAST) + IDX_W'(sel_len35);
            end
        end else if (cell_end) begin
            cyc <= '0;
            if (idx == last_idx) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    // Running parity over the cells already sent; cleared by load and start.
    always_ff @(posedge clk) begin
        if (!rst_n || !load_n) par_acc <= 1'b0;
        else if (!active)      par_acc <= 1'b0;
        else if (cell_end)     par_acc <= par_acc ^ cur_bit;
    end

    // Payload shifters, loaded at start and advanced after each body cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_word  <= '0;
            sh_short <= '0;
        end else if (!active) begin
            sh_word  <= word_q;
            sh_short <= short_q;
        end else if (cell_end && seg == SEG_BODY) begin
            if (short_lat) sh_short <= {sh_short[SHORT_W-2:0], 1'b0};
            else           sh_word  <= {sh_word[DATA_W-2:0], 1'b0};
        end
    end

    // Decode the segment of the current cell.
    always_comb begin
        if (idx == '0)              seg = SEG_SYNC;
        else if (idx == IDX_W'(1))  seg = SEG_FLAG;
        else if (idx <= body_last)  seg = SEG_BODY;
        else                        seg = SEG_PAR;
    end

    // Select the bit value of the current cell.
    always_comb begin
        unique case (seg)
            SEG_SYNC: cur_bit = SYNC_BIT;
            SEG_FLAG: cur_bit = flag_q;
            SEG_BODY: cur_bit = short_lat ? sh_short[SHORT_W-1] : sh_word[DATA_W-1];
            default:  cur_bit = par_acc ^ odd_lat;
        endcase
    end

    assign first_half = (cyc < HALF);

    // R2
    cell_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cyc != CELL_LAST) |=> ((active && cyc == $past(cyc) + 1'b1) || !load_q));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> !active);
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= last_idx));
    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start_pulse));

endmodule

// File: rtl/mwt_line_route.sv
// Output steering: biphase-encodes the current bit and sends it on the line
// pair or the loopback pair. The pair not in use is parked at its fixed level.
// Assumes line_mode is synchronous to clk.
module mwt_line_route
    import mwt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_mode,
    input  logic active,
    input  logic cur_bit,
    input  logic first_half,
    output logic line_p,
    output logic line_n,
    output logic loop_p,
    output logic loop_n
);
    logic lvl;

    assign lvl = manch_level(cur_bit, first_half);

    // Drive the carrying pair with data, the other pair with its idle level.
    always_comb begin
        if (line_mode) begin
            line_p = active & lvl;
            line_n = active & ~lvl;
            loop_p = 1'b0;
            loop_n = 1'b0;
        end else begin
            line_p = 1'b1;
            line_n = 1'b1;
            loop_p = active & lvl;
            loop_n = active & ~lvl;
        end
    end

    // R8
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_mode |-> (!loop_p && !loop_n));
    // R8
    line_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_mode |-> (line_p && line_n));
    // R3
    comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (line_mode ? (line_p != line_n) : (loop_p != loop_n)));

endmodule

// File: rtl/manch_word_tx.sv
// Manchester serial word encoder top: start synchronizer, frame sequencer
// and output steering.
// Assumes a single clock; only start_async may be asynchronous.
module manch_word_tx #(
    parameter int DATA_W     = 32,
    parameter int SHORT_W    = 4,
    parameter int CELL_CLKS  = 4,
    parameter int SYNC_STAGE = 2,
    parameter bit SYNC_BIT   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [DATA_W-1:0]  word_in,
    input  logic               flag_in,
    input  logic [SHORT_W-1:0] short_in,
    input  logic               start_async,
    input  logic               sel_len34,
    input  logic               sel_len35,
    input  logic               sel_short,
    input  logic               odd_par,
    input  logic               line_mode,
    output logic               line_p,
    output logic               line_n,
    output logic               loop_p,
    output logic               loop_n,
    output logic               tx_idle
);
    logic start_pulse, active, cur_bit, first_half;

    mwt_start_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_async(start_async), .start_pulse(start_pulse)
    );

    mwt_frame_ctrl #(
        .DATA_W(DATA_W), .SHORT_W(SHORT_W), .CELL_CLKS(CELL_CLKS), .SYNC_BIT(SYNC_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .word_in(word_in),
        .flag_in(flag_in), .short_in(short_in), .start_pulse(start_pulse),
        .sel_len34(sel_len34), .sel_len35(sel_len35), .sel_short(sel_short),
        .odd_par(odd_par), .active(active), .cur_bit(cur_bit), .first_half(first_half)
    );

    mwt_line_route u_route (
        .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .active(active),
        .cur_bit(cur_bit), .first_half(first_half),
        .line_p(line_p), .line_n(line_n), .loop_p(loop_p), .loop_n(loop_n)
    );

    assign tx_idle = ~active;

    // R1
    idle_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !$past(load_n)) |-> tx_idle);

endmodule

// File: tb/sim_manch_word_tx.sv
module sim_manch_word_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int SW = 4;

    logic clk = 1'b0, rst_n = 1'b0, load_n = 1'b1;
    logic [DW-1:0] word_in = '0;
    logic flag_in = 1'b0;
    logic [SW-1:0] short_in = '0;
    logic start_async = 1'b0, sel_len34 = 1'b0, sel_len35 = 1'b0;
    logic sel_short = 1'b0, odd_par = 1'b0, line_mode = 1'b1;
    logic line_p, line_n, loop_p, loop_n, tx_idle;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    manch_word_tx u0 (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .word_in(word_in),
        .flag_in(flag_in), .short_in(short_in), .start_async(start_async),
        .sel_len34(sel_len34), .sel_len35(sel_len35), .sel_short(sel_short),
        .odd_par(odd_par), .line_mode(line_mode), .line_p(line_p), .line_n(line_n),
        .loop_p(loop_p), .loop_n(loop_n), .tx_idle(tx_idle)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected cell sequence from the requirements (R4, R5, R6, R7).
    task automatic build_exp(input logic [DW-1:0] w, input logic f, input logic [SW-1:0] s,
                             input logic s35, input logic ss, input logic odd,
                             output logic [63:0] e, output int len);
        int body;
        e = '0;
        body = ss ? SW : DW;
        e[0] = 1'b1;
        e[1] = f;
        for (int i = 0; i < body; i++) e[2+i] = ss ? s[SW-1-i] : w[DW-1-i];
        len = 2 + body;
        if (s35) begin
            e[len] = (^e) ^ odd;
            len++;
        end
    endtask

    task automatic load_data(input logic [DW-1:0] w, input logic f, input logic [SW-1:0] s);
        @(negedge clk);
        word_in = w; flag_in = f; short_in = s; load_n = 1'b0;
        repeat (2) @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        word_in = ~w; flag_in = ~f; short_in = ~s;   // R4: must be ignored
    endtask

    task automatic run_frame(input bit expect_frame, input int len, input logic [63:0] exp,
                             input bit mid_pulse, input int abort_cell);
        int waited = 0;
        int errs = 0;
        logic [63:0] got = '0;
        logic h1, h2, pp, pn;
        start_async = 1'b1;
        do begin @(negedge clk); waited++; end while (tx_idle && waited < 8);
        start_async = 1'b0;
        if (!expect_frame) begin
            repeat (8) @(negedge clk);
            check(tx_idle == 1'b1, "R5 start ignored without length select", 64'(tx_idle), 64'd1);
            return;
        end
        check(waited == 3, "R9 start latency", 64'(waited), 64'd3);
        for (int c = 0; c < len; c++) begin
            if (mid_pulse && c == 2) start_async = 1'b1;
            if (mid_pulse && c == 5) start_async = 1'b0;
            if (c == abort_cell) begin
                load_n = 1'b0;
                @(negedge clk);
                check(tx_idle == 1'b1, "R10 abort on load low", 64'(tx_idle), 64'd1);
                load_n = 1'b1;
                @(negedge clk);
                return;
            end
            for (int h = 0; h < 2; h++) begin
                pp = line_mode ? line_p : loop_p;
                pn = line_mode ? line_n : loop_n;
                if (pp == pn) errs++;                                  // R3
                if (line_mode && (loop_p || loop_n)) errs++;           // R8
                if (!line_mode && !(line_p && line_n)) errs++;         // R8
                if (h == 0) h1 = pp; else h2 = pp;
                if (h == 0) repeat (2) @(negedge clk);
            end
            if (h1 == h2) errs++;                                      // R2
            got[c] = h1;
            @(negedge clk);
            if (tx_idle) errs++;
            @(negedge clk);
        end
        check(tx_idle == 1'b1, "R5 frame length", 64'(tx_idle), 64'd1);
        check(got == exp, "R4 R6 R7 frame cells", got, exp);
        check(errs == 0, "R2 R3 R8 cell shape and routing", 64'(errs), 64'd0);
        check(line_mode ? (!line_p && !line_n) : (!loop_p && !loop_n),
              "R8 idle carrying pair", {62'd0, line_p | loop_p, line_n | loop_n}, 64'd0);
        repeat (8) @(negedge clk);
        check(tx_idle == 1'b1, "R9 no second frame", 64'(tx_idle), 64'd1);
    endtask

    task automatic do_case(input logic [DW-1:0] w, input logic f, input logic [SW-1:0] s,
                           input logic s34, input logic s35, input logic ss, input logic odd,
                           input logic mode, input bit mid, input int abort_cell);
        logic [63:0] e;
        int len;
        build_exp(w, f, s, s35, ss, odd, e, len);
        load_data(w, f, s);
        sel_len34 = s34; sel_len35 = s35; sel_short = ss; odd_par = odd; line_mode = mode;
        @(negedge clk);
        run_frame(s34 | s35, len, e, mid, abort_cell);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_idle == 1'b1, "R1 reset idle", 64'(tx_idle), 64'd1);
        check(!line_p && !line_n && !loop_p && !loop_n, "R1 R8 reset outputs",
              {60'd0, line_p, line_n, loop_p, loop_n}, 64'd0);

        // R1: start while load is held low is ignored
        sel_len35 = 1'b1;
        load_n = 1'b0;
        start_async = 1'b1;
        repeat (8) @(negedge clk);
        check(tx_idle == 1'b1, "R1 no start while load low", 64'(tx_idle), 64'd1);
        start_async = 1'b0;
        load_n = 1'b1;
        repeat (4) @(negedge clk);

        do_case(32'h8000_0001, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, -1);
        do_case(32'hFFFF_FFFF, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        do_case(32'h0000_0000, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, -1);
        do_case(32'h1234_5678, 1'b1, 4'hA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, -1); // R7
        do_case(32'h1234_5678, 1'b0, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, -1); // R7
        do_case(32'hA5A5_0F0F, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, -1); // R9
        do_case(32'hDEAD_BEEF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, -1); // R5
        do_case(32'hCAFE_F00D, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12); // R10
        do_case(32'h0000_0007, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, -1); // R10 parity

        for (int k = 0; k < 30; k++) begin
            logic s34, s35;
            s35 = 1'($urandom_range(0, 1));
            s34 = 1'($urandom_range(0, 1)) | ~s35;
            do_case($urandom, 1'($urandom), 4'($urandom), s34, s35,
                    1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), 1'b0, -1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule